// File: doc/BRIEF.md
# Network Controller Status and Interrupt Flags

This block holds the status flags of a token-passing network controller. Network events (packet stored, acknowledge received, last byte sent, line idle timeout, software reset, node-ID write) arrive as single-cycle pulses and set flags. Decoded command pulses clear them: enable receive, enable transmit, disable transmitter and clear flags. The CPU reads one 8-bit status word.

A mask register chooses which of three flags (receiver inhibited, reconfiguration, transmitter available) drive the interrupt line. The block also tells the receive engine when to answer an incoming packet with a NAK, which it does while the receiver is inhibited.

Every flag is a register, so a pulse shows on `status_o` one clock after its edge. The mask is also a register. `irq_o` is combinational from the flags and the mask, so it follows either of them in the same cycle that they change.

Top module: `netc_status_flags`

## Requirements
- R1: After reset, status_o reads 0x91 (bit 7 receiver inhibited, bit 4 power-on reset, bit 0 transmitter available, all other bits 0), the mask is 0x00, irq_o is 0 and nak_o is 1.
- R2: Bit 7 (receiver inhibited) is set one cycle after pkt_stored_i and cleared one cycle after cmd_en_rx_i.
- R3: nak_o is 1 exactly when status bit 7 is 1.
- R4: Bit 4 (power-on reset) is set by sw_reset_i or by nid_wr_i with nid_data_i equal to 0x00. A node-ID write of any nonzero value leaves it unchanged. cmd_clr_flags_i clears it.
- R5: Bit 2 (reconfiguration) is set by idle_timeout_i and cleared by cmd_clr_flags_i.
- R6: Status bits 6, 5 and 3 always read 0.
- R7: Bit 1 (transmit acknowledged) is set by tx_ack_i only when tx_bcast_i is 0 and an enable-transmit has been issued with no disable-transmitter since. Otherwise the pulse is ignored. cmd_en_tx_i clears bit 1.
- R8: Bit 0 (transmitter available) is set by last_byte_i or cmd_dis_tx_i. After cmd_en_tx_i, the next token_i clears it. A token_i with no enable-transmit waiting, or one that comes after a disable-transmitter, leaves it unchanged.
- R9: irq_o = (bit7 & mask[7]) | (bit2 & mask[2]) | (bit0 & mask[0]). The other mask bits have no effect. A mask write shows on irq_o one cycle after the write.
- R10: When a set event and a clear event hit the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_stored_i | input | 1 | Received packet stored in the selected page |
| tx_ack_i | input | 1 | Sent packet acknowledged |
| tx_bcast_i | input | 1 | Current transmit is a broadcast |
| last_byte_i | input | 1 | Last byte of the queued packet sent |
| token_i | input | 1 | Node received the token |
| idle_timeout_i | input | 1 | Line idle timer expired |
| sw_reset_i | input | 1 | Software reset event |
| nid_wr_i | input | 1 | Node-ID register write strobe |
| nid_data_i | input | 8 | Node-ID write data |
| cmd_en_rx_i | input | 1 | Enable-receive command |
| cmd_en_tx_i | input | 1 | Enable-transmit command |
| cmd_dis_tx_i | input | 1 | Disable-transmitter command |
| cmd_clr_flags_i | input | 1 | Clear-flags command |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 8 | Mask write data |
| status_o | output | 8 | Status word |
| irq_o | output | 1 | Interrupt request |
| nak_o | output | 1 | Answer incoming packets with NAK |

## Verification
A flag stuck in a wrong state shows on `status_o` one cycle after the pulse that should have moved it. It also shows on `irq_o` in that cycle whenever the matching mask bit is set. An error in the transmit pending state is hidden until the next token or acknowledge pulse. The bench therefore sends tokens and acknowledges both with and without a preceding enable-transmit, and checks bits 0 and 1 one cycle later. A wrong receiver-inhibit state appears on `nak_o` at once.

// File: rtl/nsf_pkg.sv
package nsf_pkg;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned B_RI      = 7;
  localparam int unsigned B_POR     = 4;
  localparam int unsigned B_RECON   = 2;
  localparam int unsigned B_TMA     = 1;
  localparam int unsigned B_TA      = 0;
  localparam logic [STAT_W-1:0] IRQ_SRC_MASK = 8'h85;
endpackage

// File: rtl/nsf_flag.sv
module nsf_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (set_i)  q_o <= 1'b1;   // set wins over clear
    else if (clr_i)  q_o <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
endmodule

// File: rtl/nsf_tx_ctl.sv
module nsf_tx_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_tx_i,
  input  logic dis_tx_i,
  input  logic token_i,
  input  logic last_byte_i,
  input  logic ack_i,
  input  logic bcast_i,
  output logic ta_o,
  output logic tma_o
);
  logic wait_q, armed_q;

  // enable-transmit waiting for the token
  nsf_flag #(.RST_VAL(1'b0)) u_wait (
    .clk_i, .rst_ni, .set_i(en_tx_i), .clr_i(token_i | dis_tx_i), .q_o(wait_q));

  // transmit issued and not cancelled: acknowledges are meaningful
  nsf_flag #(.RST_VAL(1'b0)) u_armed (
    .clk_i, .rst_ni, .set_i(en_tx_i), .clr_i(dis_tx_i), .q_o(armed_q));

  nsf_flag #(.RST_VAL(1'b1)) u_ta (
    .clk_i, .rst_ni, .set_i(last_byte_i | dis_tx_i), .clr_i(token_i & wait_q), .q_o(ta_o));

  nsf_flag #(.RST_VAL(1'b0)) u_tma (
    .clk_i, .rst_ni, .set_i(ack_i & ~bcast_i & armed_q), .clr_i(en_tx_i), .q_o(tma_o));

  p_ta_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_byte_i | dis_tx_i) |=> ta_o);
  p_ta_token_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ta_o && !wait_q) |=> ta_o);
  p_tma_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tma_o && !armed_q) |=> !tma_o);
  p_tma_bcast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tma_o && bcast_i) |=> !tma_o);
endmodule

// File: rtl/nsf_irq.sv
module nsf_irq #(
  parameter int unsigned W = nsf_pkg::STAT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_wr_i,
  input  logic [W-1:0] mask_data_i,
  input  logic [W-1:0] status_i,
  output logic         irq_o
);
  import nsf_pkg::*;
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_data_i;
  end

  assign irq_o = |(status_i & mask_q & IRQ_SRC_MASK);

  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_i[B_RI] | status_i[B_RECON] | status_i[B_TA]));
  p_irq_mask_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && mask_data_i == '0) |=> !irq_o);
endmodule

// File: rtl/netc_status_flags.sv
module netc_status_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pkt_stored_i,
  input  logic       tx_ack_i,
  input  logic       tx_bcast_i,
  input  logic       last_byte_i,
  input  logic       token_i,
  input  logic       idle_timeout_i,
  input  logic       sw_reset_i,
  input  logic       nid_wr_i,
  input  logic [7:0] nid_data_i,
  input  logic       cmd_en_rx_i,
  input  logic       cmd_en_tx_i,
  input  logic       cmd_dis_tx_i,
  input  logic       cmd_clr_flags_i,
  input  logic       mask_wr_i,
  input  logic [7:0] mask_data_i,
  output logic [7:0] status_o,
  output logic       irq_o,
  output logic       nak_o
);
  import nsf_pkg::*;
  localparam int unsigned N_SIMPLE = 3;
  localparam logic [N_SIMPLE-1:0] SIMPLE_RST = 3'b011; // {recon, por, ri}

  logic [N_SIMPLE-1:0] s_set, s_clr, s_q;
  logic ta, tma;

  assign s_set = {idle_timeout_i,
                  sw_reset_i | (nid_wr_i && nid_data_i == '0),
                  pkt_stored_i};
  assign s_clr = {cmd_clr_flags_i, cmd_clr_flags_i, cmd_en_rx_i};

  for (genvar g = 0; g < N_SIMPLE; g++) begin : g_flag
    nsf_flag #(.RST_VAL(SIMPLE_RST[g])) u_flag (
      .clk_i, .rst_ni, .set_i(s_set[g]), .clr_i(s_clr[g]), .q_o(s_q[g]));
  end

  nsf_tx_ctl u_tx (
    .clk_i, .rst_ni,
    .en_tx_i(cmd_en_tx_i), .dis_tx_i(cmd_dis_tx_i), .token_i(token_i),
    .last_byte_i(last_byte_i), .ack_i(tx_ack_i), .bcast_i(tx_bcast_i),
    .ta_o(ta), .tma_o(tma));

  always_comb begin
    status_o          = '0;   // reserved and test bits stay 0
    status_o[B_RI]    = s_q[0];
    status_o[B_POR]   = s_q[1];
    status_o[B_RECON] = s_q[2];
    status_o[B_TMA]   = tma;
    status_o[B_TA]    = ta;
  end

  assign nak_o = s_q[0];

  nsf_irq #(.W(STAT_W)) u_irq (
    .clk_i, .rst_ni, .mask_wr_i, .mask_data_i, .status_i(status_o), .irq_o);

  p_ri_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_stored_i |=> status_o[B_RI]);
  p_ri_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_rx_i && !pkt_stored_i) |=> !status_o[B_RI]);
  p_nak_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_stored_i |=> nak_o);
  p_por_nz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[B_POR] && !sw_reset_i && nid_wr_i && nid_data_i != '0) |=> !status_o[B_POR]);
  p_recon_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_timeout_i |=> status_o[B_RECON]);
  p_recon_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_clr_flags_i && !idle_timeout_i) |=> !status_o[B_RECON]);
endmodule

// File: tb/netc_status_flags_tb.sv
module netc_status_flags_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pkt_stored_i = 0, tx_ack_i = 0, tx_bcast_i = 0, last_byte_i = 0, token_i = 0;
  logic idle_timeout_i = 0, sw_reset_i = 0, nid_wr_i = 0;
  logic [7:0] nid_data_i = '0;
  logic cmd_en_rx_i = 0, cmd_en_tx_i = 0, cmd_dis_tx_i = 0, cmd_clr_flags_i = 0;
  logic mask_wr_i = 0;
  logic [7:0] mask_data_i = '0;
  logic [7:0] status_o;
  logic irq_o, nak_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  netc_status_flags u_dut (.*, .clk_i(clk));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // release all pulses one negedge later; outputs are settled after the posedge between
  task automatic tick();
    @(negedge clk);
    {pkt_stored_i, tx_ack_i, tx_bcast_i, last_byte_i, token_i, idle_timeout_i} = '0;
    {sw_reset_i, nid_wr_i, cmd_en_rx_i, cmd_en_tx_i, cmd_dis_tx_i, cmd_clr_flags_i, mask_wr_i} = '0;
    chk("R6 reserved", status_o & 8'h68, 8'h00);
    chk("R3 nak", {7'd0, nak_o}, {7'd0, status_o[7]});
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 8'h91);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 nak", {7'd0, nak_o}, 8'h01);
  endtask

  task automatic t_rx();
    cmd_en_rx_i = 1; tick();
    chk("R2 ri clr", status_o, 8'h11);
    chk("R3 nak off", {7'd0, nak_o}, 8'h00);
    pkt_stored_i = 1; tick();
    chk("R2 ri set", status_o, 8'h91);
    cmd_en_rx_i = 1; pkt_stored_i = 1; tick();
    chk("R10 ri set wins", {7'd0, status_o[7]}, 8'h01);
    cmd_en_rx_i = 1; tick();
    chk("R2 ri clr again", {7'd0, status_o[7]}, 8'h00);
  endtask

  task automatic t_por();
    cmd_clr_flags_i = 1; tick();
    chk("R4 por clr", {7'd0, status_o[4]}, 8'h00);
    nid_wr_i = 1; nid_data_i = 8'h05; tick();
    chk("R4 nid nonzero", {7'd0, status_o[4]}, 8'h00);
    nid_wr_i = 1; nid_data_i = 8'h00; tick();
    chk("R4 nid zero", {7'd0, status_o[4]}, 8'h01);
    cmd_clr_flags_i = 1; tick();
    sw_reset_i = 1; tick();
    chk("R4 sw reset", {7'd0, status_o[4]}, 8'h01);
    cmd_clr_flags_i = 1; sw_reset_i = 1; tick();
    chk("R10 por set wins", {7'd0, status_o[4]}, 8'h01);
    cmd_clr_flags_i = 1; tick();
    chk("R4 por clr again", {7'd0, status_o[4]}, 8'h00);
  endtask

  task automatic t_recon();
    idle_timeout_i = 1; tick();
    chk("R5 recon set", {7'd0, status_o[2]}, 8'h01);
    cmd_clr_flags_i = 1; tick();
    chk("R5 recon clr", {7'd0, status_o[2]}, 8'h00);
  endtask

  task automatic t_tx();
    tx_ack_i = 1; tick();
    chk("R7 ack unarmed", {6'd0, status_o[1:0]}, 8'h01);
    token_i = 1; tick();
    chk("R8 token idle", {7'd0, status_o[0]}, 8'h01);
    cmd_en_tx_i = 1; tick();
    chk("R8 ta held until token", {7'd0, status_o[0]}, 8'h01);
    token_i = 1; tick();
    chk("R8 token clears ta", {7'd0, status_o[0]}, 8'h00);
    tx_ack_i = 1; tx_bcast_i = 1; tick();
    chk("R7 bcast ack", {7'd0, status_o[1]}, 8'h00);
    last_byte_i = 1; tick();
    chk("R8 last byte", {7'd0, status_o[0]}, 8'h01);
    tx_ack_i = 1; tick();
    chk("R7 ack set", {7'd0, status_o[1]}, 8'h01);
    cmd_en_tx_i = 1; tick();
    chk("R7 en_tx clr tma", {7'd0, status_o[1]}, 8'h00);
    token_i = 1; last_byte_i = 1; tick();
    chk("R10 ta set wins", {7'd0, status_o[0]}, 8'h01);
    cmd_en_tx_i = 1; tick();
    cmd_dis_tx_i = 1; tick();
    chk("R8 disable sets ta", {7'd0, status_o[0]}, 8'h01);
    token_i = 1; tick();
    chk("R8 token after disable", {7'd0, status_o[0]}, 8'h01);
    tx_ack_i = 1; tick();
    chk("R7 ack after disable", {7'd0, status_o[1]}, 8'h00);
  endtask

  task automatic t_irq();
    // state: ri=0 recon=0 ta=1
    mask_wr_i = 1; mask_data_i = 8'h80; tick();
    chk("R9 ri masked off", {7'd0, irq_o}, 8'h00);
    pkt_stored_i = 1; tick();
    chk("R9 ri irq", {7'd0, irq_o}, 8'h01);
    idle_timeout_i = 1; mask_wr_i = 1; mask_data_i = 8'h7A; tick();
    chk("R9 other mask bits", {7'd0, irq_o}, 8'h00);
    mask_wr_i = 1; mask_data_i = 8'h04; tick();
    chk("R9 recon irq", {7'd0, irq_o}, 8'h01);
    mask_wr_i = 1; mask_data_i = 8'h01; tick();
    chk("R9 ta irq", {7'd0, irq_o}, 8'h01);
    cmd_en_tx_i = 1; tick();
    token_i = 1; tick();
    chk("R9 ta gone", {7'd0, irq_o}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx();
    t_por();
    t_recon();
    t_tx();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule